// File: doc/BRIEF.md
# Edge/Level Interrupt Status Controller

This block gathers a group of single-bit event lines into sticky status registers and folds them into one interrupt pin. The lines are grouped into banks of equal width. Each line has an enable bit and a two-bit detection mode. The mode is stored as one bit in a "mode high" register and one bit in a "mode low" register, both at the same bit position as the status bit. The mode selects capture of a rising edge, capture of a falling edge, or a live level. A status bit caught on an edge stays set until software reads that bank's status register. The read returns the bits and clears the edge-captured ones in the same cycle. A level bit simply tracks its line.

Only some bit positions in each bank are wired to real sources. This is set by a per-bit implementation mask parameter, which by default populates bits 7, 6, 2, 1 and 0 of bank 0 and bits 3, 2 and 1 of bank 1. The pin can drive active-high, drive active-low, or act as an open-drain pull-down. Open-drain uses a separate output-enable line.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all status, enable and mode bits and the pin configuration are 0. rdata is 0. The pin is in active-high mode and inactive: irq_o=0, irq_oe_o=1.
- R2: Mode {high,low}=00 captures a rising edge. When a line sampled 0 at one clock edge is 1 at the next, its status bit is set at that edge. It stays set after the line falls.
- R3: Mode 01 captures a falling edge, with the same timing as R2. A rising edge has no effect on the status bit in this mode.
- R4: Modes 10 and 11 are level modes. The status bit is loaded with the line's value at every clock edge. A status read does not clear it.
- R5: A read of a bank's status register returns the pre-read value on rdata in the cycle after the read edge. At that same edge it clears the edge-captured bits. An edge captured at the read edge itself is kept.
- R6: The interrupt is active when any status bit with enable bit 1 is set. A disabled bit still shows in its status register.
- R7: Pin configuration bits [1:0]: 00 gives irq_o=active, irq_oe_o=1. 01 gives irq_o=!active, irq_oe_o=1. 10 and 11 give irq_o=0, irq_oe_o=active.
- R8: Bit positions absent from the implementation mask read 0 in every bank register, never set status, and never raise the interrupt.
- R9: Address map: bank b uses addresses 4b+0 (status, read only; writes ignored), 4b+1 (enable), 4b+2 (mode high) and 4b+3 (mode low). Address 4*NUM_BANKS holds the pin configuration in bits [1:0]. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_BANKS*BANK_W | Event lines, bank b at bits [b*BANK_W +: BANK_W] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | BANK_W | Write data |
| rdata | output | BANK_W | Read data, registered |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
An event line changed before a clock edge shows up in status at that edge. The pin responds in the same cycle as the status change, so the bench samples it on the following falling edge. Read data is registered, so each expected value is pushed into a queue while the read is issued. The monitor compares it at the falling edge after the read edge. The hardest case is a read issued in the same cycle as a new edge: the bench expects the old value back and the new bit on the next read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REGS_PER_BANK = 4;

    typedef enum logic [1:0] {
        DET_RISE      = 2'b00,
        DET_FALL      = 2'b01,
        DET_LEVEL     = 2'b10,
        DET_LEVEL_ALT = 2'b11
    } det_mode_e;

    typedef enum logic [1:0] {
        PIN_HIGH   = 2'b00,
        PIN_LOW    = 2'b01,
        PIN_OD     = 2'b10,
        PIN_OD_ALT = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_ENAB = 2'd1,
        SEL_MHI  = 2'd2,
        SEL_MLO  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic o;
        logic oe;
    } pin_drive_t;

    function automatic det_mode_e decode_mode(logic hi, logic lo);
        return det_mode_e'({hi, lo});
    endfunction

    function automatic logic is_level(det_mode_e m);
        return (m == DET_LEVEL) || (m == DET_LEVEL_ALT);
    endfunction

    function automatic pin_drive_t drive_pin(pin_mode_e m, logic act);
        pin_drive_t d;
        case (m)
            PIN_HIGH: begin d.o = act;  d.oe = 1'b1; end
            PIN_LOW:  begin d.o = !act; d.oe = 1'b1; end
            default:  begin d.o = 1'b0; d.oe = act;  end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] mode_hi,
    input  logic [W-1:0] mode_lo,
    input  logic         clr,
    output logic [W-1:0] status,
    output logic [W-1:0] level
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= evt & IMPL;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_on
            det_mode_e m;
            logic      hit;
            logic      stat_q;

            always_comb begin
                m = decode_mode(mode_hi[i], mode_lo[i]);
                case (m)
                    DET_RISE: hit = evt[i] & ~prev_q[i];
                    DET_FALL: hit = ~evt[i] & prev_q[i];
                    default:  hit = 1'b0;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst)              stat_q <= 1'b0;
                else if (is_level(m)) stat_q <= evt[i];
                else                  stat_q <= (stat_q & ~clr) | hit;
            end

            assign status[i] = stat_q;
            assign level[i]  = is_level(m);
        end else begin : g_off
            logic unused_bit;
            assign unused_bit = evt[i] ^ mode_hi[i] ^ mode_lo[i] ^ prev_q[i];
            assign status[i]  = 1'b0;
            assign level[i]   = 1'b0;
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter logic [NUM_BANKS*BANK_W-1:0] IMPL = '1,
    parameter int ADDR_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BANK_W-1:0]             wdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   status,
    output logic [NUM_BANKS*BANK_W-1:0]   enab,
    output logic [NUM_BANKS*BANK_W-1:0]   mode_hi,
    output logic [NUM_BANKS*BANK_W-1:0]   mode_lo,
    output pin_mode_e                     pin_cfg,
    output logic [NUM_BANKS-1:0]          clr,
    output logic [BANK_W-1:0]             rdata
);

    localparam int CFG_ADDR = NUM_BANKS * REGS_PER_BANK;

    reg_sel_e          sel;
    logic [ADDR_W-3:0] bank_idx;
    logic              in_banks;
    logic              cfg_hit;
    logic [BANK_W-1:0] rd_bank [NUM_BANKS];
    logic [BANK_W-1:0] rd_next;
    logic [BANK_W-1:0] rdata_q;

    assign sel      = reg_sel_e'(addr[1:0]);
    assign bank_idx = addr[ADDR_W-1:2];
    assign in_banks = int'(addr) < CFG_ADDR;
    assign cfg_hit  = int'(addr) == CFG_ADDR;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] IM = IMPL[b*BANK_W +: BANK_W];
        logic              hit;
        logic [BANK_W-1:0] enab_q, hi_q, lo_q;

        assign hit = in_banks && (int'(bank_idx) == b);

        always_ff @(posedge clk) begin
            if (rst) begin
                enab_q <= '0;
                hi_q   <= '0;
                lo_q   <= '0;
            end else if (wr_en && hit) begin
                case (sel)
                    SEL_ENAB: enab_q <= wdata & IM;
                    SEL_MHI:  hi_q   <= wdata & IM;
                    SEL_MLO:  lo_q   <= wdata & IM;
                    default:  ;
                endcase
            end
        end

        assign enab[b*BANK_W +: BANK_W]    = enab_q;
        assign mode_hi[b*BANK_W +: BANK_W] = hi_q;
        assign mode_lo[b*BANK_W +: BANK_W] = lo_q;
        assign clr[b] = rd_en && hit && (sel == SEL_STAT);

        always_comb begin
            if (!hit) rd_bank[b] = '0;
            else begin
                case (sel)
                    SEL_STAT: rd_bank[b] = status[b*BANK_W +: BANK_W];
                    SEL_ENAB: rd_bank[b] = enab_q;
                    SEL_MHI:  rd_bank[b] = hi_q;
                    default:  rd_bank[b] = lo_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  pin_cfg <= PIN_HIGH;
        else if (wr_en && cfg_hit) pin_cfg <= pin_mode_e'(wdata[1:0]);
    end

    always_comb begin
        rd_next = '0;
        if (cfg_hit) rd_next[1:0] = pin_cfg;
        for (int b = 0; b < NUM_BANKS; b++) rd_next = rd_next | rd_bank[b];
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/irqc_pin.sv
module irqc_pin
    import irqc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] status,
    input  logic [N-1:0] enab,
    input  pin_mode_e    pin_cfg,
    output logic         irq_o,
    output logic         irq_oe_o
);

    logic       active;
    pin_drive_t drv;

    assign active   = |(status & enab);
    assign drv      = drive_pin(pin_cfg, active);
    assign irq_o    = drv.o;
    assign irq_oe_o = drv.oe;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8,
    parameter logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK = 16'h0EC7,
    localparam int ADDR_W   = $clog2(NUM_BANKS*REGS_PER_BANK+1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*BANK_W-1:0] evt_i,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BANK_W-1:0]           wdata,
    output logic [BANK_W-1:0]           rdata,
    output logic                        irq_o,
    output logic                        irq_oe_o
);

    localparam int N = NUM_BANKS * BANK_W;

    logic [N-1:0]         status_all, level_all, enab_all, hi_all, lo_all;
    logic [NUM_BANKS-1:0] clr;
    pin_mode_e            pin_cfg;

    irqc_regs #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .IMPL(IMPL_MASK), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .status(status_all), .enab(enab_all), .mode_hi(hi_all),
        .mode_lo(lo_all), .pin_cfg(pin_cfg), .clr(clr), .rdata(rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_det
        irqc_detect #(
            .W(BANK_W), .IMPL(IMPL_MASK[b*BANK_W +: BANK_W])
        ) u_det (
            .clk(clk), .rst(rst),
            .evt(evt_i[b*BANK_W +: BANK_W]),
            .mode_hi(hi_all[b*BANK_W +: BANK_W]),
            .mode_lo(lo_all[b*BANK_W +: BANK_W]),
            .clr(clr[b]),
            .status(status_all[b*BANK_W +: BANK_W]),
            .level(level_all[b*BANK_W +: BANK_W])
        );
    end

    irqc_pin #(.N(N)) u_pin (
        .status(status_all), .enab(enab_all), .pin_cfg(pin_cfg),
        .irq_o(irq_o), .irq_oe_o(irq_oe_o)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int N = 16,
    parameter int BANK_W = 8,
    parameter int NB = 2,
    parameter logic [N-1:0] IMPL = '1,
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  evt,
    input logic [N-1:0]  status,
    input logic [N-1:0]  enab,
    input logic [N-1:0]  level,
    input logic [NB-1:0] clr,
    input logic [1:0]    cfg,
    input logic          irq_o,
    input logic          irq_oe_o,
    input logic [RW-1:0] rdata
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == '0) && (enab == '0) && (rdata == '0) && (cfg == 2'b00));

    // R6
    irq_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg == 2'b00) |-> (irq_o == |(status & enab)) && irq_oe_o);

    // R7
    irq_od_chk: assert property (@(posedge clk) disable iff (rst)
        cfg[1] |-> (!irq_o && (irq_oe_o == |(status & enab))));

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (IMPL[i]) begin : g_on
            localparam int B = i / BANK_W;
            // R4
            level_track_chk: assert property (@(posedge clk) disable iff (rst)
                $past(level[i]) |-> (status[i] == $past(evt[i])));
            // R5
            edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
                ($past(status[i]) && !$past(level[i]) && !$past(clr[B])) |-> status[i]);
        end
    end

endmodule

bind evt_irq_ctrl irqc_chk #(
    .N(NUM_BANKS*BANK_W), .BANK_W(BANK_W), .NB(NUM_BANKS), .IMPL(IMPL_MASK), .RW(BANK_W)
) u_chk (
    .clk(clk), .rst(rst), .evt(evt_i), .status(status_all), .enab(enab_all),
    .level(level_all), .clr(clr), .cfg(pin_cfg), .irq_o(irq_o),
    .irq_oe_o(irq_oe_o), .rdata(rdata)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_o, irq_oe_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } rd_item_t;
    rd_item_t exp_q[$];
    logic     rd_seen = 1'b0;

    always #5 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
    );

    // monitor: rdata is due in the cycle after the read edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            rd_item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected read result %h, expected none", "R5", rdata);
            end else begin
                it = exp_q.pop_front();
                if (rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: rdata=%h expected %h", it.req, rdata, it.exp);
                end
            end
        end
    end

    task automatic do_read(input logic [3:0] a, input logic [7:0] e, input string req);
        rd_item_t it;
        @(negedge clk);
        it.exp = e; it.req = req;
        exp_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_evt(input int idx, input logic v);
        @(negedge clk);
        evt_i[idx] = v;
        @(negedge clk);
    endtask

    task automatic chk_pin(input logic eo, input logic eoe, input string req);
        checks++;
        if (irq_o !== eo || irq_oe_o !== eoe) begin
            fails++;
            $display("FAIL %s: pin o/oe=%b%b expected %b%b", req, irq_o, irq_oe_o, eo, eoe);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_pin(1'b0, 1'b1, "R1");
        do_read(4'd0, 8'h00, "R1");
        do_read(4'd1, 8'h00, "R1");
        do_read(4'd8, 8'h00, "R1");

        // R9 / R8 enable register with unimplemented bits
        do_write(4'd1, 8'hFF);
        do_read(4'd1, 8'hC7, "R8");

        // R2 rising edge
        set_evt(0, 1'b1);
        chk_pin(1'b1, 1'b1, "R6");
        set_evt(0, 1'b0);
        do_read(4'd0, 8'h01, "R2");
        do_read(4'd0, 8'h00, "R5");
        chk_pin(1'b0, 1'b1, "R6");

        // R3 falling edge on bit1
        do_write(4'd3, 8'h02);
        set_evt(1, 1'b1);
        do_read(4'd0, 8'h00, "R3");
        set_evt(1, 1'b0);
        do_read(4'd0, 8'h02, "R3");
        do_read(4'd0, 8'h00, "R5");

        // R4 level modes: bit7 = 10, bit6 = 11
        do_write(4'd2, 8'hC0);
        do_write(4'd3, 8'h42);
        set_evt(7, 1'b1);
        set_evt(6, 1'b1);
        do_read(4'd0, 8'hC0, "R4");
        do_read(4'd0, 8'hC0, "R4");
        set_evt(7, 1'b0);
        do_read(4'd0, 8'h40, "R4");
        set_evt(6, 1'b0);
        do_read(4'd0, 8'h00, "R4");

        // R5 edge arriving at the read edge is kept
        begin
            rd_item_t it;
            @(negedge clk);
            evt_i[0] = 1'b1;
            it.exp = 8'h00; it.req = "R5";
            exp_q.push_back(it);
            rd_en = 1'b1; addr = 4'd0;
            @(negedge clk);
            rd_en = 1'b0;
        end
        do_read(4'd0, 8'h01, "R5");
        set_evt(0, 1'b0);
        do_read(4'd0, 8'h00, "R5");

        // R6 disabled bit and R7 pin styles
        do_write(4'd1, 8'h00);
        set_evt(2, 1'b1);
        chk_pin(1'b0, 1'b1, "R6");
        do_write(4'd1, 8'h04);
        chk_pin(1'b1, 1'b1, "R6");
        do_write(4'd8, 8'h01);
        chk_pin(1'b0, 1'b1, "R7");
        do_write(4'd8, 8'h02);
        chk_pin(1'b0, 1'b1, "R7");
        do_read(4'd0, 8'h04, "R6");
        chk_pin(1'b0, 1'b0, "R7");
        do_write(4'd8, 8'h03);
        chk_pin(1'b0, 1'b0, "R7");
        do_write(4'd8, 8'h01);
        chk_pin(1'b1, 1'b1, "R7");
        do_write(4'd8, 8'h00);
        chk_pin(1'b0, 1'b1, "R7");
        set_evt(2, 1'b0);

        // R8 unimplemented sources
        do_write(4'd1, 8'hFF);
        set_evt(3, 1'b1);
        set_evt(8, 1'b1);
        chk_pin(1'b0, 1'b1, "R8");
        do_read(4'd0, 8'h00, "R8");
        do_read(4'd4, 8'h00, "R8");
        do_write(4'd5, 8'hFF);
        do_read(4'd5, 8'h0E, "R8");
        do_write(4'd6, 8'hFF);
        do_read(4'd6, 8'h0E, "R8");
        chk_pin(1'b0, 1'b1, "R8");

        // R9 map details
        do_write(4'd0, 8'hFF);
        do_read(4'd0, 8'h00, "R9");
        do_read(4'd12, 8'h00, "R9");
        do_write(4'd8, 8'h03);
        do_read(4'd8, 8'h03, "R9");
        do_write(4'd8, 8'h00);

        // bank 1 bit1 in level mode
        set_evt(9, 1'b1);
        chk_pin(1'b1, 1'b1, "R6");
        do_read(4'd4, 8'h02, "R9");
        set_evt(9, 1'b0);
        do_read(4'd4, 8'h00, "R4");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R5: %0d reads pending, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule